// File: doc/BRIEF.md
# Qualified Trigger Capture Engine

This block watches a stream of signed samples, qualifies a trigger event in one of four selectable ways, and captures a record around it. Every accepted sample goes into a circular buffer, so a history of samples before the event is always on hand. When a trigger is accepted, the block fixes the start of the record, keeps writing until the post-trigger window is full, and then plays the record out oldest-first on a valid/ready port.

Each trigger mode has its own noise guard. Edge detection needs the signal to return past an opposite threshold before it can fire again. Level detection blocks further triggers for a holdoff number of samples. Window detection needs an excursion out of the band to last a set number of samples. A software pulse is held until the next valid sample and fires on that sample. Each played-out record carries its trigger timestamp, the mode that fired, the pre- and post-trigger lengths actually used, and a flag for a short history. Configuration inputs are expected to stay stable while a capture is in progress.

Top module: `trig_capture`

## Requirements
- R1: Mode 0 (edge). With `cfg_pol`=0, a sample <= `cfg_lo` arms the detector and a later armed sample >= `cfg_hi` fires and disarms it. With `cfg_pol`=1, a sample >= `cfg_hi` arms it and a later armed sample <= `cfg_lo` fires. Samples between the two thresholds never re-arm the detector. The detector is disarmed after reset.
- R2: Mode 1 (level). A sample fires when it is >= `cfg_hi` (`cfg_pol`=0) or <= `cfg_lo` (`cfg_pol`=1). After a level trigger, the next `cfg_holdoff` valid samples cannot fire.
- R3: Mode 2 (window). A sample is out of band when it is >= `cfg_hi` or <= `cfg_lo`. A trigger fires on the Nth consecutive out-of-band sample, where N is `cfg_dwell` (0 is treated as 1). It fires only once per excursion, and an in-band sample restarts the count.
- R4: Mode 3 (software). A `sw_trig` pulse fires on the same cycle's valid sample, or on the next valid sample if none is present in that cycle.
- R5: Every valid sample is written to the ring except during readout. A record is the pre-trigger samples that come before the trigger sample, then the trigger sample, then the samples after it up to the post length. The post length counts the trigger sample.
- R6: With depth D = 2^AW, the pre length is capped at D-1. The post length is capped at D minus the pre length, and a post length of 0 is treated as 1.
- R7: If fewer samples than the pre length have been written since arming began, the record starts at the oldest of those samples, `out_pre` reports that smaller count, and `out_short` is 1.
- R8: During readout, `out_ts` holds the count of valid samples since reset that came before the trigger sample. `out_type` holds the mode code, and `out_pre`/`out_post` hold the lengths used.
- R9: A readout beat transfers when `out_valid` and `out_ready` are both 1. While stalled, the data and markers hold. `out_sor` marks the first beat and `out_eor` the last. After the last beat, `out_valid` drops and arming restarts with an empty history.
- R10: A qualified trigger during the post window or during readout does not change the record. It increments `trig_missed`, which saturates at 255.
- R11: After reset, `out_valid` is 0 and `trig_missed` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample present |
| in_data | input | DW | Signed sample |
| cfg_mode | input | 2 | 0 edge, 1 level, 2 window, 3 software |
| cfg_pol | input | 1 | Edge direction / level side |
| cfg_hi | input | DW | Upper threshold (signed) |
| cfg_lo | input | DW | Lower threshold (signed) |
| cfg_holdoff | input | HW | Level holdoff in samples |
| cfg_dwell | input | HW | Window dwell in samples |
| cfg_pre | input | AW+1 | Requested pre-trigger length |
| cfg_post | input | AW+1 | Requested post-trigger length |
| sw_trig | input | 1 | Software trigger pulse |
| out_ready | input | 1 | Consumer ready |
| out_valid | output | 1 | Readout beat present |
| out_data | output | DW | Record sample |
| out_sor | output | 1 | First beat of record |
| out_eor | output | 1 | Last beat of record |
| out_ts | output | TSW | Trigger timestamp |
| out_type | output | 2 | Mode that fired |
| out_pre | output | AW+1 | Pre-trigger samples in record |
| out_post | output | AW+1 | Post-trigger samples in record |
| out_short | output | 1 | Pre-trigger history was short |
| trig_missed | output | 8 | Triggers ignored while busy |

## Verification
A post-window write and a second qualified trigger can fall on the same sample. The block must store the sample but leave the record untouched and only count the trigger. The bench provokes this by asserting the software trigger alongside a sample inside the post window. It then checks that the played-out timestamp and contents still belong to the first trigger and that the missed count has risen by exactly one. A sweep over every pre/post pair, including the clamped ones, checks each played-out sample against the index arithmetic.

// File: rtl/trig_capture.sv
module trig_capture #(
  parameter int DW  = 12,
  parameter int AW  = 4,
  parameter int TSW = 16,
  parameter int HW  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_data,
  input  logic [1:0]           cfg_mode,
  input  logic                 cfg_pol,
  input  logic signed [DW-1:0] cfg_hi,
  input  logic signed [DW-1:0] cfg_lo,
  input  logic [HW-1:0]        cfg_holdoff,
  input  logic [HW-1:0]        cfg_dwell,
  input  logic [AW:0]          cfg_pre,
  input  logic [AW:0]          cfg_post,
  input  logic                 sw_trig,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [DW-1:0]        out_data,
  output logic                 out_sor,
  output logic                 out_eor,
  output logic [TSW-1:0]       out_ts,
  output logic [1:0]           out_type,
  output logic [AW:0]          out_pre,
  output logic [AW:0]          out_post,
  output logic                 out_short,
  output logic [7:0]           trig_missed
);
  localparam int DEPTH = 1 << AW;
  localparam int LW = AW + 1;
  localparam logic [LW-1:0] PRE_MAX = LW'(DEPTH - 1);
  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  typedef enum logic [1:0] {S_ARMING, S_ARMED, S_TRIG, S_READ} st_t;
  st_t st;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] fill, rec_len, rd_cnt, post_left;
  logic [TSW-1:0] ts_cnt;
  logic edge_arm, sw_pend;
  logic [HW-1:0] hold, dwell_cnt;

  logic [LW-1:0] pre_c, room, post_m, post_c, avail;
  assign pre_c  = (cfg_pre > PRE_MAX) ? PRE_MAX : cfg_pre;
  assign room   = DEPTH_L - pre_c;
  assign post_m = (cfg_post > room) ? room : cfg_post;
  assign post_c = (post_m == '0) ? LW'(1) : post_m;
  assign avail  = (fill < pre_c) ? fill : pre_c;

  logic hi_hit, lo_hit, oob, edge_fire, lvl_fire, win_fire, fire;
  logic [HW:0] dwell_eff;
  assign hi_hit    = in_data >= cfg_hi;
  assign lo_hit    = in_data <= cfg_lo;
  assign oob       = hi_hit || lo_hit;
  assign edge_fire = edge_arm && (cfg_pol ? lo_hit : hi_hit);
  assign lvl_fire  = (cfg_pol ? lo_hit : hi_hit) && (hold == '0);
  assign dwell_eff = (cfg_dwell == '0) ? (HW+1)'(1) : {1'b0, cfg_dwell};
  assign win_fire  = oob && (({1'b0, dwell_cnt} + 1'b1) == dwell_eff);

  always_comb begin
    case (cfg_mode)
      2'd0:    fire = edge_fire;
      2'd1:    fire = lvl_fire;
      2'd2:    fire = win_fire;
      default: fire = sw_trig || sw_pend;
    endcase
  end

  logic trig, busy, wr_en;
  assign trig  = in_valid && fire;
  assign busy  = (st == S_TRIG) || (st == S_READ);
  assign wr_en = in_valid && (st != S_READ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      edge_arm  <= 1'b0;
      hold      <= '0;
      dwell_cnt <= '0;
      sw_pend   <= 1'b0;
    end else begin
      if (in_valid) begin
        if (edge_fire) edge_arm <= 1'b0;
        else if (cfg_pol ? hi_hit : lo_hit) edge_arm <= 1'b1;
        if (lvl_fire) hold <= cfg_holdoff;
        else if (hold != '0) hold <= hold - 1'b1;
        if (!oob) dwell_cnt <= '0;
        else if (!(&dwell_cnt)) dwell_cnt <= dwell_cnt + 1'b1;
        sw_pend <= 1'b0;
      end else if (sw_trig) begin
        sw_pend <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_ARMING;
      wr_ptr <= '0; rd_ptr <= '0; fill <= '0; rec_len <= '0;
      rd_cnt <= '0; post_left <= '0; ts_cnt <= '0; trig_missed <= '0;
      out_ts <= '0; out_type <= '0; out_pre <= '0; out_post <= '0; out_short <= 1'b0;
    end else begin
      if (in_valid) ts_cnt <= ts_cnt + 1'b1;
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (trig && busy && trig_missed != 8'hFF) trig_missed <= trig_missed + 1'b1;
      case (st)
        S_ARMING, S_ARMED: begin
          if (trig) begin
            rd_ptr    <= wr_ptr - avail[AW-1:0];
            rd_cnt    <= '0;
            rec_len   <= avail + post_c;
            post_left <= post_c - 1'b1;
            out_ts    <= ts_cnt;
            out_type  <= cfg_mode;
            out_pre   <= avail;
            out_post  <= post_c;
            out_short <= avail < pre_c;
            st        <= (post_c == LW'(1)) ? S_READ : S_TRIG;
          end else begin
            if (wr_en && fill < PRE_MAX) fill <= fill + 1'b1;
            if (st == S_ARMING && fill >= pre_c) st <= S_ARMED;
          end
        end
        S_TRIG: begin
          if (in_valid) begin
            post_left <= post_left - 1'b1;
            if (post_left == LW'(1)) st <= S_READ;
          end
        end
        default: begin
          if (out_ready) begin
            rd_ptr <= rd_ptr + 1'b1;
            rd_cnt <= rd_cnt + 1'b1;
            if (out_eor) begin
              st   <= S_ARMING;
              fill <= '0;
            end
          end
        end
      endcase
    end
  end

  assign out_valid = (st == S_READ);
  assign out_data  = mem[rd_ptr];
  assign out_sor   = (rd_cnt == '0);
  assign out_eor   = (rd_cnt == rec_len - 1'b1);

  p_len_fits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rec_len <= DEPTH_L && rec_len != '0));
  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sor) && $stable(out_eor));
  p_eor_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_eor && out_ready));
  p_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_eor |=> out_valid && !out_sor);
  p_missed_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    trig_missed != $past(trig_missed) |-> $past(st == S_TRIG || st == S_READ));
  p_short_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_short |-> out_pre < pre_c);
endmodule

// File: tb/trig_capture_tb.sv
module trig_capture_tb;
  localparam int DW = 12, AW = 4, TSW = 16, HW = 8;
  localparam int D = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, sw_trig = 1'b0, out_ready = 1'b0;
  logic signed [DW-1:0] in_data = '0, cfg_hi = 12'sd1000, cfg_lo = -12'sd1000;
  logic [1:0] cfg_mode = '0;
  logic cfg_pol = 1'b0;
  logic [HW-1:0] cfg_holdoff = '0, cfg_dwell = '0;
  logic [AW:0] cfg_pre = '0, cfg_post = '0;
  logic out_valid, out_sor, out_eor, out_short;
  logic [DW-1:0] out_data;
  logic [TSW-1:0] out_ts;
  logic [1:0] out_type;
  logic [AW:0] out_pre, out_post;
  logic [7:0] trig_missed;

  trig_capture #(.DW(DW), .AW(AW), .TSW(TSW), .HW(HW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .cfg_mode(cfg_mode), .cfg_pol(cfg_pol), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
    .cfg_holdoff(cfg_holdoff), .cfg_dwell(cfg_dwell), .cfg_pre(cfg_pre),
    .cfg_post(cfg_post), .sw_trig(sw_trig), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .out_sor(out_sor), .out_eor(out_eor),
    .out_ts(out_ts), .out_type(out_type), .out_pre(out_pre), .out_post(out_post),
    .out_short(out_short), .trig_missed(trig_missed));

  always #5 clk = ~clk;

  int nchk = 0, nerr = 0, gts = 0, nstim = 0, pre_i = 0, post_i = 0;
  int stim [64];
  bit swgap [64];
  bit swon [64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_stim();
    for (int i = 0; i < 64; i++) begin stim[i] = 0; swgap[i] = 0; swon[i] = 0; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; sw_trig = 1'b0; out_ready = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    gts = 0;
  endtask

  task automatic run_capture(input int tpos, input string req);
    int pre_e, room, post_e, avail, len, base, sent, k, guard;
    pre_e = (pre_i > D - 1) ? D - 1 : pre_i;
    room = D - pre_e;
    post_e = (post_i > room) ? room : post_i;
    if (post_e == 0) post_e = 1;
    avail = (tpos < pre_e) ? tpos : pre_e;
    len = avail + post_e;
    cfg_pre = (AW+1)'(pre_i);
    cfg_post = (AW+1)'(post_i);
    base = gts;
    sent = 0;
    while (1) begin
      @(negedge clk);
      if (out_valid) break;
      if (sent >= nstim) begin
        chk(0, {req, " no trigger seen"}, sent, tpos);
        in_valid = 1'b0; sw_trig = 1'b0;
        return;
      end
      if (swgap[sent]) begin
        in_valid = 1'b0; sw_trig = 1'b1;
        @(negedge clk);
      end
      in_valid = 1'b1; in_data = DW'(stim[sent]); sw_trig = swon[sent];
      sent++; gts++;
    end
    in_valid = 1'b0; sw_trig = 1'b0;
    chk(sent == tpos + post_e, {req, " samples until readout"}, sent, tpos + post_e);
    k = 0; guard = 0;
    while (k < len && guard < 200) begin
      @(negedge clk);
      out_ready = (guard % 3) != 2;
      guard++;
      #1;
      if (out_valid && out_ready) begin
        chk($signed(out_data) == stim[tpos - avail + k], {req, " R5 record data"},
            $signed(out_data), stim[tpos - avail + k]);
        chk(out_sor == (k == 0), {req, " R9 sor"}, out_sor, k == 0);
        chk(out_eor == (k == len - 1), {req, " R9 eor"}, out_eor, k == len - 1);
        if (k == 0) begin
          chk(int'(out_ts) == base + tpos, {req, " R8 timestamp"}, out_ts, base + tpos);
          chk(out_type == cfg_mode, {req, " R8 type"}, out_type, cfg_mode);
          chk(int'(out_pre) == avail, {req, " R7 pre used"}, out_pre, avail);
          chk(int'(out_post) == post_e, {req, " R6 post used"}, out_post, post_e);
          chk(out_short == (avail < pre_e), {req, " R7 short"}, out_short, avail < pre_e);
        end
        k++;
      end
    end
    chk(k == len, {req, " R9 beat count"}, k, len);
    @(negedge clk);
    out_ready = 1'b0;
    #1;
    chk(!out_valid, {req, " R9 valid drops"}, out_valid, 0);
  endtask

  initial begin
    #1500000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    do_reset();
    #1;
    chk(!out_valid, "R11 reset valid", out_valid, 0);
    chk(trig_missed == 0, "R11 reset missed", trig_missed, 0);

    // R1 R5 R6 R7 R8: sweep every pre/post pair around a rising edge at position 10
    cfg_mode = 2'd0; cfg_pol = 1'b0;
    clear_stim();
    for (int i = 0; i < 40; i++) stim[i] = (i < 10) ? -1100 - i : 1100 + i;
    nstim = 40;
    for (int p = 0; p <= D + 1; p++)
      for (int q = 0; q <= D + 1; q++) begin
        pre_i = p; post_i = q;
        run_capture(10, "R1 sweep");
      end
    chk(trig_missed == 0, "R10 no missed in sweep", trig_missed, 0);

    // R1 hysteresis: chatter above threshold without re-arm must not fire
    do_reset();
    clear_stim();
    stim[0] = 5; stim[1] = 1201; stim[2] = 6; stim[3] = 1202; stim[4] = 7;
    stim[5] = 1203; stim[6] = -1204; stim[7] = 1205; stim[8] = 1206; stim[9] = 1207;
    nstim = 10; pre_i = 4; post_i = 2;
    run_capture(7, "R1 rising hysteresis");

    // R1 falling edge
    do_reset();
    cfg_pol = 1'b1;
    clear_stim();
    stim[0] = -1201; stim[1] = 1202; stim[2] = 5; stim[3] = -1203;
    stim[4] = -1204; stim[5] = -1205; stim[6] = -1206;
    nstim = 7; pre_i = 2; post_i = 3;
    run_capture(3, "R1 falling");

    // R2 level with holdoff 5: second capture fires 6 samples after the first trigger
    do_reset();
    cfg_mode = 2'd1; cfg_pol = 1'b0; cfg_holdoff = 8'd5;
    clear_stim();
    stim[0] = 10; stim[1] = 11; stim[2] = 1200; stim[3] = 1201; stim[4] = 12;
    nstim = 5; pre_i = 2; post_i = 2;
    run_capture(2, "R2 level first");
    clear_stim();
    for (int i = 0; i < 12; i++) stim[i] = 1300 + i;
    nstim = 12;
    run_capture(4, "R2 level holdoff");

    // R2 level below, no holdoff
    do_reset();
    cfg_pol = 1'b1; cfg_holdoff = 8'd0;
    clear_stim();
    stim[0] = 20; stim[1] = 21; stim[2] = 22; stim[3] = -1200; stim[4] = 23;
    nstim = 5; pre_i = 3; post_i = 1;
    run_capture(3, "R2 level below");

    // R3 window dwell 3, broken excursion then a full one
    do_reset();
    cfg_mode = 2'd2; cfg_pol = 1'b0; cfg_dwell = 8'd3;
    clear_stim();
    stim[0] = 0; stim[1] = 1200; stim[2] = 1201; stim[3] = 5; stim[4] = -1200;
    stim[5] = -1201; stim[6] = -1202; stim[7] = -1203; stim[8] = 1204;
    nstim = 9; pre_i = 4; post_i = 2;
    run_capture(6, "R3 window dwell");
    clear_stim();
    stim[0] = 6; stim[1] = 1300; stim[2] = 1301; stim[3] = 1302; stim[4] = 1303;
    nstim = 5;
    run_capture(3, "R3 window re-qualify");
    cfg_dwell = 8'd1;
    clear_stim();
    stim[0] = 7; stim[1] = 8; stim[2] = -1300; stim[3] = 9;
    nstim = 4;
    run_capture(2, "R3 window dwell one");

    // R4 software: pulse in a gap, then pulse with a sample
    do_reset();
    cfg_mode = 2'd3;
    clear_stim();
    for (int i = 0; i < 10; i++) stim[i] = 40 + i;
    swgap[5] = 1;
    nstim = 10; pre_i = 3; post_i = 2;
    run_capture(5, "R4 software pending");
    clear_stim();
    for (int i = 0; i < 10; i++) stim[i] = 60 + i;
    swon[2] = 1;
    nstim = 10;
    run_capture(2, "R4 software same cycle");
    chk(trig_missed == 0, "R10 missed before collision", trig_missed, 0);

    // R10 second trigger during the post window
    clear_stim();
    for (int i = 0; i < 10; i++) stim[i] = 80 + i;
    swon[1] = 1; swon[3] = 1;
    nstim = 10; pre_i = 1; post_i = 4;
    run_capture(1, "R10 collision");
    chk(trig_missed == 1, "R10 missed count", trig_missed, 1);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule